// File: doc/BRIEF.md
# Attack-Decay-Sustain-Release Envelope Generator

This block shapes the loudness of one synthesizer voice. A gate input opens and closes the note. Two 8-bit parameter bytes select the rates and the sustain level. The block produces an 8-bit envelope level, and a multiplier further down the datapath scales the voice waveform by it. The level moves in single-unit steps. The time between steps comes from a table of sixteen rate codes. Each code names the time a full 256-step sweep should take. A tick input that pulses once per microsecond times the steps.

When the gate opens, the level climbs to full scale at the attack rate. It then falls at the decay rate to the sustain target and stays there while the gate remains high. When the gate closes, the level falls at the release rate to zero, and the block then goes idle. If the gate opens again before the release has finished, the attack starts again from the level already reached. The parameter `TIME_DIV` divides every step period, so that a shortened time base can be used.

Top module: `adsr_envelope`

## Requirements
- R1: A synchronous active-high reset puts the block in its idle phase with `env_level` = 0.
- R2: A rising edge on `gate` enters the attack phase. Each attack step raises the level by 1. One step after the level reaches 255, the decay phase begins.
- R3: In decay, each step lowers the level by 1 until it is at or below the sustain target. The next step then enters sustain. The target is the sustain nibble written into both halves of a byte, so nibble 0xA gives 0xAA.
- R4: In sustain, the level holds constant for as long as `gate` stays high.
- R5: A falling edge on `gate` in any non-idle phase enters release. Each step lowers the level by 1. The step after the level reaches 0 returns to idle, and in idle the level is 0.
- R6: A rising edge on `gate` during release (or at any other time) restarts the attack from the current level, without clearing it.
- R7: Attack step period, in ticks, is floor(T_a(code)·1000 / 256 / TIME_DIV). T_a in ms for codes 0..15 is 2, 8, 16, 24, 38, 56, 68, 80, 100, 250, 500, 800, 1000, 3000, 5000, 8000. The counter reloads on every step and on every phase entry.
- R8: Decay and release step periods use three times the attack time of the same code, with the same formula.
- R9: Field positions: `shape_cfg[7:4]` holds the attack code and `shape_cfg[3:0]` holds the decay code. `hold_cfg[7:4]` holds the sustain nibble and `hold_cfg[3:0]` holds the release code.
- R10: The level never changes in a cycle without `tick_us` high. With `tick_us` held low, the level stays frozen.
- R11: A computed step period of 0 is raised to 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle time-base pulse (1 µs nominal) |
| gate | input | 1 | Note gate |
| shape_cfg | input | 8 | Attack code [7:4], decay code [3:0] |
| hold_cfg | input | 8 | Sustain nibble [7:4], release code [3:0] |
| env_level | output | 8 | Envelope level |

## Verification
The bench builds the block with `TIME_DIV` = 1000. With that value, even the slowest release code (93 ticks per step) finishes a full sweep within a few tens of thousands of cycles, so random gate patterns reach every phase and every code. The fastest codes fall below one tick and are raised to 1, which brings the R11 floor within reach. A cycle-level reference model drives the per-cycle comparison. Directed windows measure step spacing for an attack code, for a release code and for the clamped code, and check the frozen level while the tick is held low.

// File: rtl/adsr_pkg.sv
package adsr_pkg;

    localparam int LVL_W      = 8;
    localparam int CODE_W     = 4;
    localparam int NUM_CODES  = 1 << CODE_W;
    localparam int SWEEP      = 256;
    localparam int SLOW_MUL   = 3;
    localparam int MAX_TICKS  = 8_000_000 * SLOW_MUL / SWEEP;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  ticks_t;

    typedef enum logic [2:0] {
        ENV_IDLE,
        ENV_ATTACK,
        ENV_DECAY,
        ENV_SUSTAIN,
        ENV_RELEASE
    } env_phase_t;

    typedef struct packed {
        code_t rise_code;
        code_t fall_code;
        code_t hold_nib;
        code_t end_code;
    } env_codes_t;

    function automatic env_codes_t split_cfg(input logic [7:0] shape, input logic [7:0] hold);
        env_codes_t c;
        c.rise_code = shape[7:4];
        c.fall_code = shape[3:0];
        c.hold_nib  = hold[7:4];
        c.end_code  = hold[3:0];
        return c;
    endfunction

    function automatic level_t widen_nibble(input code_t n);
        return {n, n};
    endfunction

    // Full-sweep attack time in microseconds for each code.
    function automatic int unsigned sweep_us(input int unsigned code);
        case (code)
            0:  return 2_000;
            1:  return 8_000;
            2:  return 16_000;
            3:  return 24_000;
            4:  return 38_000;
            5:  return 56_000;
            6:  return 68_000;
            7:  return 80_000;
            8:  return 100_000;
            9:  return 250_000;
            10: return 500_000;
            11: return 800_000;
            12: return 1_000_000;
            13: return 3_000_000;
            14: return 5_000_000;
            default: return 8_000_000;
        endcase
    endfunction

    function automatic ticks_t step_ticks(input int unsigned code, input bit slow,
                                          input int unsigned div);
        int unsigned t;
        t = sweep_us(code) * (slow ? SLOW_MUL : 1) / SWEEP / div;
        if (t == 0) t = 1;
        return ticks_t'(t);
    endfunction

    function automatic logic is_ramp(input env_phase_t p);
        return (p == ENV_ATTACK) || (p == ENV_DECAY) || (p == ENV_RELEASE);
    endfunction

endpackage

// File: rtl/adsr_rate_lut.sv
module adsr_rate_lut
    import adsr_pkg::*;
#(
    parameter int TIME_DIV = 1
) (
    input  env_phase_t phase_sel,
    input  env_codes_t codes,
    output ticks_t     reload_val
);
    ticks_t fast_tbl [NUM_CODES];
    ticks_t slow_tbl [NUM_CODES];

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_rate
        assign fast_tbl[i] = step_ticks(i, 1'b0, TIME_DIV);
        assign slow_tbl[i] = step_ticks(i, 1'b1, TIME_DIV);
    end

    ticks_t period;
    always_comb begin
        case (phase_sel)
            ENV_DECAY:   period = slow_tbl[codes.fall_code];
            ENV_RELEASE: period = slow_tbl[codes.end_code];
            default:     period = fast_tbl[codes.rise_code];
        endcase
        reload_val = period - ticks_t'(1);
    end

    always_comb begin
        assert (period != '0) else $error("AST_PERIOD_NONZERO"); // R11
    end
endmodule

// File: rtl/adsr_step_timer.sv
module adsr_step_timer
    import adsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   run,
    input  logic   reload,
    input  ticks_t reload_val,
    output logic   step
);
    ticks_t cnt;

    assign step = run & tick & (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (reload)
            cnt <= reload_val;
        else if (run && tick)
            cnt <= cnt - ticks_t'(1);
    end

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        step |-> tick); // R10
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= ticks_t'(MAX_TICKS)); // R7
endmodule

// File: rtl/adsr_phase_fsm.sv
module adsr_phase_fsm
    import adsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gate,
    input  logic       step,
    input  level_t     hold_target,
    output env_phase_t phase,
    output env_phase_t phase_nx,
    output level_t     level,
    output logic       reload
);
    logic   gate_q;
    logic   gate_up, gate_dn;
    level_t level_nx;

    assign gate_up = gate & ~gate_q;
    assign gate_dn = ~gate & gate_q & (phase != ENV_IDLE);

    always_comb begin
        phase_nx = phase;
        level_nx = level;
        if (gate_up) begin
            phase_nx = ENV_ATTACK;
        end else if (gate_dn) begin
            phase_nx = ENV_RELEASE;
        end else if (step) begin
            case (phase)
                ENV_ATTACK:
                    if (level == '1) phase_nx = ENV_DECAY;
                    else             level_nx = level + level_t'(1);
                ENV_DECAY:
                    if (level <= hold_target) phase_nx = ENV_SUSTAIN;
                    else                      level_nx = level - level_t'(1);
                ENV_RELEASE:
                    if (level == '0) phase_nx = ENV_IDLE;
                    else             level_nx = level - level_t'(1);
                default: ;
            endcase
        end
    end

    assign reload = gate_up | gate_dn | step;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            phase  <= ENV_IDLE;
            level  <= '0;
        end else begin
            gate_q <= gate;
            phase  <= phase_nx;
            level  <= level_nx;
        end
    end

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(level) |-> ((level_t'(level - $past(level)) == level_t'(1)) ||
                             (level_t'($past(level) - level) == level_t'(1)))); // R2
    AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == ENV_IDLE) |-> (level == '0)); // R5
    AST_SUSTAIN_FLAT: assert property (@(posedge clk) disable iff (rst)
        (phase == ENV_SUSTAIN && $past(phase) == ENV_SUSTAIN) |-> $stable(level)); // R4
    AST_RISE_TO_ATTACK: assert property (@(posedge clk) disable iff (rst)
        gate_up |=> (phase == ENV_ATTACK)); // R6
    AST_FALL_TO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        gate_dn |=> (phase == ENV_RELEASE)); // R5
endmodule

// File: rtl/adsr_envelope.sv
module adsr_envelope
    import adsr_pkg::*;
#(
    parameter int TIME_DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       gate,
    input  logic [7:0] shape_cfg,
    input  logic [7:0] hold_cfg,
    output logic [7:0] env_level
);
    env_codes_t codes;
    env_phase_t phase, phase_nx;
    level_t     level;
    ticks_t     reload_val;
    logic       reload, step;

    assign codes = split_cfg(shape_cfg, hold_cfg);

    adsr_rate_lut #(.TIME_DIV(TIME_DIV)) u_lut (
        .phase_sel  (phase_nx),
        .codes      (codes),
        .reload_val (reload_val)
    );

    adsr_step_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_us),
        .run        (is_ramp(phase)),
        .reload     (reload),
        .reload_val (reload_val),
        .step       (step)
    );

    adsr_phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .gate        (gate),
        .step        (step),
        .hold_target (widen_nibble(codes.hold_nib)),
        .phase       (phase),
        .phase_nx    (phase_nx),
        .level       (level),
        .reload      (reload)
    );

    assign env_level = level;

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick_us && !gate && !$past(gate)) |=> $stable(env_level)); // R10
endmodule

// File: tb/adsr_envelope_test.sv
module adsr_envelope_test;
    localparam int DIV = 1000;

    logic clk = 0, rst = 1, tick_us = 0, gate = 0;
    logic [7:0] shape_cfg = 0, hold_cfg = 0;
    logic [7:0] env_level;
    int vectors = 0, errors = 0, cycles = 0;
    bit tick_rand = 0, monitor_on = 0;

    always #5 clk = ~clk;

    adsr_envelope #(.TIME_DIV(DIV)) uut (.*);

    // reference model: phases 0 idle, 1 attack, 2 decay, 3 sustain, 4 release
    int m_ph = 0, m_lvl = 0, m_cnt = 0; bit m_gq = 0;

    function automatic int ms_of(input int c);
        int t [16] = '{2,8,16,24,38,56,68,80,100,250,500,800,1000,3000,5000,8000};
        return t[c];
    endfunction

    function automatic int per(input int ph);
        int c, mul, v;
        mul = (ph == 2 || ph == 4) ? 3 : 1;
        c = (ph == 2) ? shape_cfg[3:0] : (ph == 4) ? hold_cfg[3:0] : shape_cfg[7:4];
        v = ms_of(c) * 1000 * mul / 256 / DIV;
        return (v < 1) ? 1 : v;
    endfunction

    function automatic string tag_of(input int ph);
        case (ph) 1: return "R2"; 2: return "R3"; 3: return "R4"; default: return "R5"; endcase
    endfunction

    always @(posedge clk) begin
        bit up, dn; int sus;
        cycles++;
        if (rst) begin m_ph = 0; m_lvl = 0; m_cnt = 0; m_gq = 0; end
        else begin
            up = gate && !m_gq; dn = !gate && m_gq && m_ph != 0; m_gq = gate;
            sus = hold_cfg[7:4] * 17;
            if (up) begin m_ph = 1; m_cnt = per(1) - 1; end
            else if (dn) begin m_ph = 4; m_cnt = per(4) - 1; end
            else if (tick_us && (m_ph == 1 || m_ph == 2 || m_ph == 4)) begin
                if (m_cnt != 0) m_cnt--;
                else begin
                    case (m_ph)
                        1: if (m_lvl == 255) m_ph = 2; else m_lvl++;
                        2: if (m_lvl <= sus) m_ph = 3; else m_lvl--;
                        default: if (m_lvl == 0) m_ph = 0; else m_lvl--;
                    endcase
                    m_cnt = per(m_ph) - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (tick_rand) tick_us <= ($urandom % 3) != 0;
        if (monitor_on) begin
            vectors++;
            if (env_level != m_lvl[7:0]) begin
                errors++;
                $display("FAIL %s (R6 R9 R11 model): env_level=%0d expected %0d", tag_of(m_ph), env_level, m_lvl);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // measure the spacing between two level changes, skipping the first
    task automatic step_gap(input string req, input int exp);
        logic [7:0] v; int n;
        v = env_level; while (env_level == v) @(negedge clk);
        v = env_level; n = 0;
        while (env_level == v) begin @(negedge clk); n++; end
        check(req, n, exp);
    endtask

    initial begin
        void'($urandom(32'd4242));
        wait_cyc(3);
        check("R1", env_level, 0);
        @(negedge clk) rst = 0;
        monitor_on = 1;
        wait_cyc(2);
        check("R1", env_level, 0);

        // R7: attack code 12 -> 3 ticks; R9 field positions
        tick_us = 1;
        shape_cfg = 8'hC0; hold_cfg = 8'hA0;
        gate = 1;
        step_gap("R7", 1000000 / 256 / DIV);
        wait_cyc(1200);
        check("R3 R9", env_level, 8'hAA);
        // R10: frozen without tick
        tick_us = 0; gate = 0; wait_cyc(2);
        begin logic [7:0] h; h = env_level; wait_cyc(40); check("R10", env_level, h); end
        // R8: release code 12 -> 11 ticks
        hold_cfg = 8'hAC; tick_us = 1;
        step_gap("R8", 3000000 / 256 / DIV);
        // R6: retrigger mid-release keeps level
        begin logic [7:0] h; h = env_level; gate = 1; wait_cyc(1);
              check("R6", (env_level >= h) ? 1 : 0, 1); end
        wait_cyc(2000);
        // R11: attack code 0 clamps to 1 tick
        gate = 0; hold_cfg = 8'h00; wait_cyc(400);
        check("R5", env_level, 0);
        shape_cfg = 8'h00; gate = 1;
        step_gap("R11", 1);
        wait_cyc(600);
        check("R4", env_level, 0);

        tick_rand = 1;
        for (int i = 0; i < 16; i++) begin
            shape_cfg = 8'($urandom); hold_cfg = 8'($urandom);
            gate = 1; wait_cyc($urandom % 2500);
            gate = 0; wait_cyc($urandom % 2500);
        end
        monitor_on = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule